// File: doc/BRIEF.md
# Counter-Based True LRU Tracker

This block records the exact least-recently-used order of the ways in every set of a k-way set-associative cache. Each way of each set holds a small rank. A higher rank means the way was touched more recently. When a way is touched, its rank rises to the top. Only the ranks that sat above its old rank move down by one. The way that holds rank zero is the replacement victim.

The cache controller pulses the access strobe with a set index and a way number on every hit or fill. The controller places a set index on the query port. It reads back the victim way and the rank of every way in that set, with no clock in between. In the 2-way variant the state per set shrinks to a single bit that marks the most recently used way.

Top module: `lru_rank_tracker`

## Requirements
- R1: Each way of each set owns a rank of log2(NUM_WAYS) bits. `qry_ranks` carries the rank of way w at bits [w*RANK_W +: RANK_W]. RANK_W is 2 for the default of 4 ways.
- R2: Within any set, the ranks always form a permutation of 0..NUM_WAYS-1.
- R3: An access to way i of set s takes effect at the next rising edge. Way i receives rank NUM_WAYS-1. Every other way of set s whose rank exceeded the old rank of i loses one. Ways of set s ranked below that old rank keep their rank.
- R4: `qry_victim` is the way of the queried set whose rank is zero.
- R5: An access to the way that already holds rank NUM_WAYS-1 leaves every rank of that set unchanged.
- R6: While `rst` is high at a rising edge, way w of every set is given rank w. After reset, way 0 is the victim of every set.
- R7: The query outputs depend combinationally on the stored ranks. An access and a query to the same set in one cycle return the values from before the update.
- R8: An access changes only the set it names. With `acc_valid` low, no rank changes.
- R9: With NUM_WAYS = 2, one bit per set marks the most recently used way. The victim is the other way. `qry_ranks` reports the marked way with rank 1 and the other way with rank 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset to the identity order |
| acc_valid | input | 1 | Access strobe; one access per cycle |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | RANK_W | Way touched by the access |
| qry_set | input | SET_W | Set index of the victim query |
| qry_victim | output | RANK_W | Least recently used way of the queried set |
| qry_ranks | output | NUM_WAYS*RANK_W | Rank of every way of the queried set |

## Verification
The assertions take three things for granted about the inputs. `acc_set` and `qry_set` stay below NUM_SETS. NUM_WAYS is a power of two. Reset is held for at least one rising edge before any check counts. The rank-stability and most-recently-used properties compare the query outputs against the previous cycle's access and query. For that reason they rely on the query being driven from a stable set index for a whole cycle.

The stimulus meets these assumptions in four ways:
- It draws set and way numbers only from the valid ranges.
- It holds reset from time zero.
- It changes inputs only on falling edges.
- After each access, it compares every rank against a recency-list model of each set.

// File: rtl/lru_rank_pkg.sv
package lru_rank_pkg;

  // Width of an index over n items, never less than one bit.
  function automatic int unsigned lru_rank_bits(int unsigned n);
    int unsigned b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction

endpackage

// File: rtl/lru_rank_next.sv
module lru_rank_next #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned RANK_W   = 2,
  localparam int unsigned VEC_W   = NUM_WAYS * RANK_W
) (
  input  logic [VEC_W-1:0]  cur_ranks,
  input  logic [RANK_W-1:0] hit_way,
  output logic [VEC_W-1:0]  nxt_ranks
);

  localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(NUM_WAYS - 1);

  logic [RANK_W-1:0] old_rank;

  always_comb begin
    old_rank = cur_ranks[int'(hit_way)*RANK_W +: RANK_W];
    for (int w = 0; w < NUM_WAYS; w++) begin
      logic [RANK_W-1:0] r;
      r = cur_ranks[w*RANK_W +: RANK_W];
      if (RANK_W'(w) == hit_way)
        nxt_ranks[w*RANK_W +: RANK_W] = TOP_RANK;
      else if (r > old_rank)
        nxt_ranks[w*RANK_W +: RANK_W] = r - 1'b1;
      else
        nxt_ranks[w*RANK_W +: RANK_W] = r;
    end
  end

endmodule

// File: rtl/lru_zero_pick.sv
module lru_zero_pick #(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned RANK_W   = 2,
  localparam int unsigned VEC_W   = NUM_WAYS * RANK_W
) (
  input  logic [VEC_W-1:0]  ranks,
  output logic [RANK_W-1:0] victim
);

  always_comb begin
    victim = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (ranks[w*RANK_W +: RANK_W] == '0) victim = RANK_W'(w);
    end
  end

endmodule

// File: rtl/lru_rank_tracker.sv
module lru_rank_tracker
  import lru_rank_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned RANK_W  = lru_rank_bits(NUM_WAYS),
  localparam int unsigned SET_W   = lru_rank_bits(NUM_SETS),
  localparam int unsigned VEC_W   = NUM_WAYS * RANK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic [SET_W-1:0]  acc_set,
  input  logic [RANK_W-1:0] acc_way,
  input  logic [SET_W-1:0]  qry_set,
  output logic [RANK_W-1:0] qry_victim,
  output logic [VEC_W-1:0]  qry_ranks
);

  generate
    if (NUM_WAYS == 2) begin : g_two_way
      // One MRU bit per set; reset order makes way 1 the most recent.
      logic [NUM_SETS-1:0] mru_bits;

      always_ff @(posedge clk) begin
        if (rst)
          mru_bits <= '1;
        else if (acc_valid)
          mru_bits[acc_set] <= acc_way[0];
      end

      assign qry_victim = ~mru_bits[qry_set];
      assign qry_ranks  = {mru_bits[qry_set], ~mru_bits[qry_set]};
    end else begin : g_rank_way
      logic [VEC_W-1:0] rank_mem [NUM_SETS];
      logic [VEC_W-1:0] acc_cur;
      logic [VEC_W-1:0] acc_nxt;
      logic [VEC_W-1:0] init_vec;

      always_comb begin
        for (int w = 0; w < NUM_WAYS; w++)
          init_vec[w*RANK_W +: RANK_W] = RANK_W'(w);
      end

      assign acc_cur = rank_mem[acc_set];

      lru_rank_next #(
        .NUM_WAYS (NUM_WAYS),
        .RANK_W   (RANK_W)
      ) u_next (
        .cur_ranks (acc_cur),
        .hit_way   (acc_way),
        .nxt_ranks (acc_nxt)
      );

      always_ff @(posedge clk) begin
        if (rst) begin
          for (int s = 0; s < NUM_SETS; s++) rank_mem[s] <= init_vec;
        end else if (acc_valid) begin
          rank_mem[acc_set] <= acc_nxt;
        end
      end

      assign qry_ranks = rank_mem[qry_set];

      lru_zero_pick #(
        .NUM_WAYS (NUM_WAYS),
        .RANK_W   (RANK_W)
      ) u_pick (
        .ranks  (qry_ranks),
        .victim (qry_victim)
      );
    end
  endgenerate

endmodule

// File: rtl/lru_rank_tracker_chk.sv
module lru_rank_tracker_chk
  import lru_rank_pkg::*;
#(
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned NUM_SETS = 16,
  localparam int unsigned RANK_W  = lru_rank_bits(NUM_WAYS),
  localparam int unsigned SET_W   = lru_rank_bits(NUM_SETS),
  localparam int unsigned VEC_W   = NUM_WAYS * RANK_W
) (
  input logic              clk,
  input logic              rst,
  input logic              acc_valid,
  input logic [SET_W-1:0]  acc_set,
  input logic [RANK_W-1:0] acc_way,
  input logic [SET_W-1:0]  qry_set,
  input logic [RANK_W-1:0] qry_victim,
  input logic [VEC_W-1:0]  qry_ranks
);

  localparam logic [RANK_W-1:0] TOP_RANK = RANK_W'(NUM_WAYS - 1);

  logic              prev_rst;
  logic              prev_valid;
  logic [SET_W-1:0]  prev_set;
  logic [RANK_W-1:0] prev_way;
  logic [SET_W-1:0]  prev_qset;
  logic [VEC_W-1:0]  prev_qranks;

  always_ff @(posedge clk) begin
    prev_rst    <= rst;
    prev_valid  <= rst ? 1'b0 : acc_valid;
    prev_set    <= acc_set;
    prev_way    <= acc_way;
    prev_qset   <= qry_set;
    prev_qranks <= qry_ranks;
  end

  logic [NUM_WAYS-1:0] seen;
  logic [VEC_W-1:0]    id_vec;
  logic [RANK_W-1:0]   victim_rank;
  logic [RANK_W-1:0]   touched_rank;

  always_comb begin
    seen = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      seen[qry_ranks[w*RANK_W +: RANK_W]] = 1'b1;
      id_vec[w*RANK_W +: RANK_W] = RANK_W'(w);
    end
    victim_rank  = qry_ranks[int'(qry_victim)*RANK_W +: RANK_W];
    touched_rank = qry_ranks[int'(prev_way)*RANK_W +: RANK_W];
  end

  AST_RANKS_DISTINCT: assert property (@(posedge clk) disable iff (rst)
    $countones(seen) == NUM_WAYS); // R2

  AST_VICTIM_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    victim_rank == '0); // R4

  AST_TOUCHED_IS_MRU: assert property (@(posedge clk) disable iff (rst)
    (prev_valid && qry_set == prev_set) |-> touched_rank == TOP_RANK); // R3

  AST_QUIET_SET_STABLE: assert property (@(posedge clk) disable iff (rst)
    (!prev_rst && qry_set == prev_qset && !(prev_valid && prev_set == qry_set))
      |-> qry_ranks == prev_qranks); // R8

  AST_RESET_ORDER: assert property (@(posedge clk) disable iff (rst)
    prev_rst |-> qry_ranks == id_vec); // R6

endmodule

bind lru_rank_tracker lru_rank_tracker_chk #(
  .NUM_WAYS (NUM_WAYS),
  .NUM_SETS (NUM_SETS)
) u_chk (.*);

// File: tb/lru_rank_tracker_bench.sv
module lru_rank_tracker_bench;

  localparam int NW = 4;
  localparam int NS = 16;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       acc_valid = 1'b0;
  logic [3:0] acc_set = '0;
  logic [1:0] acc_way = '0;
  logic [3:0] qry_set = '0;
  logic [1:0] qry_victim;
  logic [7:0] qry_ranks;

  logic       t_acc_valid = 1'b0;
  logic [1:0] t_acc_set = '0;
  logic       t_acc_way = 1'b0;
  logic [1:0] t_qry_set = '0;
  logic       t_qry_victim;
  logic [1:0] t_qry_ranks;

  always #10 clk = ~clk;

  lru_rank_tracker #(.NUM_WAYS(NW), .NUM_SETS(NS)) u_lru_rank_tracker (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_set(acc_set),
    .acc_way(acc_way), .qry_set(qry_set), .qry_victim(qry_victim),
    .qry_ranks(qry_ranks)
  );

  lru_rank_tracker #(.NUM_WAYS(2), .NUM_SETS(4)) u_two (
    .clk(clk), .rst(rst), .acc_valid(t_acc_valid), .acc_set(t_acc_set),
    .acc_way(t_acc_way), .qry_set(t_qry_set), .qry_victim(t_qry_victim),
    .qry_ranks(t_qry_ranks)
  );

  // {set[3:0], way[1:0], expected victim[1:0], expected ranks[7:0]}
  localparam logic [15:0] VEC_TAB [9] = '{
    16'h5CE4, 16'h5193, 16'h5972, 16'h572D, 16'h949C,
    16'h531B, 16'h5EC6, 16'h5EC6, 16'h59B1
  };

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int order [NS][NW];   // order[s][0] is least recently used

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++)
      for (int p = 0; p < NW; p++) order[s][p] = p;
  endtask

  task automatic model_access(int s, int w);
    int idx;
    idx = 0;
    for (int p = 0; p < NW; p++) if (order[s][p] == w) idx = p;
    for (int p = idx; p < NW - 1; p++) order[s][p] = order[s][p+1];
    order[s][NW-1] = w;
  endtask

  function automatic logic [7:0] model_ranks(int s);
    logic [7:0] v;
    v = '0;
    for (int p = 0; p < NW; p++) v[order[s][p]*2 +: 2] = 2'(p);
    return v;
  endfunction

  task automatic do_access(int s, int w);
    @(negedge clk);
    acc_valid = 1'b1; acc_set = 4'(s); acc_way = 2'(w);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic peek(int s);
    qry_set = 4'(s);
    #1;
  endtask

  task automatic t_access(int s, int w);
    @(negedge clk);
    t_acc_valid = 1'b1; t_acc_set = 2'(s); t_acc_way = w[0];
    @(negedge clk);
    t_acc_valid = 1'b0;
    t_qry_set = 2'(s);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R6 / R1: identity order after reset
    for (int s = 0; s < NS; s++) begin
      peek(s);
      check("R6 reset ranks", 32'(qry_ranks), 32'h0000_00E4);
      check("R6 reset victim", 32'(qry_victim), 32'h0);
    end

    // Table of directed vectors: R3, R4, R5 (repeat of MRU way), R8 (set 9)
    for (int i = 0; i < 9; i++) begin
      logic [15:0] e;
      e = VEC_TAB[i];
      do_access(int'(e[15:12]), int'(e[11:10]));
      model_access(int'(e[15:12]), int'(e[11:10]));
      peek(int'(e[15:12]));
      check("R3 table ranks", 32'(qry_ranks), 32'(e[7:0]));
      check("R4 table victim", 32'(qry_victim), 32'(e[9:8]));
    end
    peek(9);
    check("R8 set 9 kept", 32'(qry_ranks), 32'h0000_009C);
    peek(5);
    check("R5 set 5 final", 32'(qry_ranks), 32'h0000_00B1);

    // R7: same-cycle access and query return pre-update values
    begin
      int v;
      v = order[5][0];
      @(negedge clk);
      acc_valid = 1'b1; acc_set = 4'd5; acc_way = 2'(v); qry_set = 4'd5;
      #1;
      check("R7 pre-update victim", 32'(qry_victim), 32'(v));
      check("R7 pre-update ranks", 32'(qry_ranks), 32'(model_ranks(5)));
      @(negedge clk);
      acc_valid = 1'b0;
      model_access(5, v);
      #1;
      check("R3 post-update ranks", 32'(qry_ranks), 32'(model_ranks(5)));
      check("R4 post-update victim", 32'(qry_victim), 32'(order[5][0]));
    end

    // Random accesses against a recency-list model: R2, R3, R4, R8
    for (int i = 0; i < 400; i++) begin
      int s, w, o;
      s = $urandom_range(0, NS-1);
      w = $urandom_range(0, NW-1);
      o = $urandom_range(0, NS-1);
      do_access(s, w);
      model_access(s, w);
      peek(s);
      check("R3 random ranks", 32'(qry_ranks), 32'(model_ranks(s)));
      check("R4 random victim", 32'(qry_victim), 32'(order[s][0]));
      peek(o);
      check("R8 other set", 32'(qry_ranks), 32'(model_ranks(o)));
    end

    // R6: reset again from a scrambled state
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    model_reset();
    for (int s = 0; s < NS; s++) begin
      peek(s);
      check("R6 re-reset ranks", 32'(qry_ranks), 32'h0000_00E4);
      check("R6 re-reset victim", 32'(qry_victim), 32'h0);
    end

    // R9: two-way variant
    t_qry_set = 2'd2;
    #1;
    check("R9 two-way reset ranks", 32'(t_qry_ranks), 32'h2);
    check("R9 two-way reset victim", 32'(t_qry_victim), 32'h0);
    t_access(2, 1);
    check("R9 two-way MRU repeat", 32'(t_qry_ranks), 32'h2);
    t_access(2, 0);
    check("R9 two-way ranks", 32'(t_qry_ranks), 32'h1);
    check("R9 two-way victim", 32'(t_qry_victim), 32'h1);
    t_qry_set = 2'd1;
    #1;
    check("R9 two-way other set", 32'(t_qry_victim), 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule